// File: doc/BRIEF.md
# Variable-Top PWM Timer

This block is an up-counting timer with one pulse-width-modulated output. The counter runs from zero up to a programmable top value kept in a period register, then starts again at zero. A second register, the duty register, sets the count at which the output edge falls (or rises, for inverted polarity) within each period. Software writes four registers through a simple write port. The timer advances either on every clock or on a clock-enable strobe from an external prescaler; a select input chooses which.

Duty writes are double-buffered. A new duty value waits in a holding register and becomes active only when the counter goes from the top value back to zero, so no period mixes two duty values. A 2-bit compare mode either leaves the pin disconnected or chooses normal or inverted polarity. A force bit applies the compare action at once. A compare-match flag signals each match to an interrupt controller, which acknowledges it with a pulse.

Top module: `vtop_pwm_timer`

## Requirements
- R1: After reset the counter is 0, the period register is 255, the held and active duty values are 0, the compare mode is 00, `pwm_out` is 0 and `cmp_flag` is 0.
- R2: The counter changes only on an advance cycle. `clk_sel` = 00 stops the counter. `clk_sel` = 01 advances it on every clock. `clk_sel` = 10 or 11 advances it only on clocks where `tick_en` is 1.
- R3: On an advance cycle where the counter equals the period register, the counter becomes 0; otherwise it increments by one (modulo 256). The output period is therefore (period + 1) advance cycles. Writing address 3 sets the period register, and the new value takes effect immediately.
- R4: A write to address 1 loads the counter with `wr_data` in that cycle, whether or not the cycle is an advance cycle. Such a cycle produces no zero event and no match event.
- R5: With compare mode 00 or 01, `pwm_out` is held at 0.
- R6: Compare mode 10 gives non-inverted output. On an advance the counter enters a new value. If that value is 0, the output level becomes 1. If it equals the active duty value, the level becomes 0. When both happen together, the match wins.
- R7: Compare mode 11 gives inverted output. Entering the duty value sets the level to 1, and entering 0 clears it to 0. When both happen together, the match wins.
- R8: A write to address 2 goes only to the held duty value. The held value is copied to the active duty value when the counter wraps from the period value to 0. The match test on that wrap already uses the newly copied value.
- R9: A duty value above the period value never matches. The output keeps the level set at the zero point for the whole period.
- R10: A write to address 0 sets the compare mode from `wr_data[1:0]`. If `wr_data[2]` is also 1 and the new mode is 10 or 11, the level is set in the next cycle as if a match had occurred: 0 for mode 10, 1 for mode 11. The force does not set `cmp_flag`, and it takes priority over any event in the same cycle.
- R11: `cmp_flag` is set in the cycle after a match event, in any compare mode. It is cleared by `irq_ack` or by a write to address 0 with `wr_data[3]` = 1. If a set and a clear occur in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 counter, 2 duty, 3 period |
| wr_data | input | 8 | Write data |
| clk_sel | input | 2 | Advance source: 00 stop, 01 every clock, 1x prescaler enable |
| tick_en | input | 1 | Clock enable from the external prescaler |
| irq_ack | input | 1 | Interrupt acknowledge pulse, clears the flag |
| pwm_out | output | 1 | PWM output pin |
| cmp_flag | output | 1 | Compare-match flag |
| count_out | output | 8 | Current counter value |

## Verification
Every register in the block is updated on the edge that samples its cause. A write, an advance or an acknowledge at edge k therefore shows on `count_out`, `pwm_out` and `cmp_flag` right after edge k, and a change of compare mode reaches `pwm_out` in that same cycle. The bench drives inputs shortly after each rising edge. Its behavioural model steps on the same rising edge using the inputs it sampled there. All three outputs are compared with the model at every falling edge, so each result is checked in the exact cycle it is due. The scenarios cover the period wrap, the buffered duty update, the two polarities, the out-of-range duty, force, and flag set/clear collisions.

// File: rtl/vtp_pkg.sv
package vtp_pkg;
   localparam int unsigned ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_CTRL   = 2'd0,
      REG_COUNT  = 2'd1,
      REG_DUTY   = 2'd2,
      REG_PERIOD = 2'd3
   } reg_addr_e;

   typedef enum logic [1:0] {
      SRC_STOP = 2'd0,
      SRC_FREE = 2'd1,
      SRC_EXT0 = 2'd2,
      SRC_EXT1 = 2'd3
   } clk_src_e;

   localparam int unsigned CTL_MODE_LSB = 0;
   localparam int unsigned CTL_FORCE    = 2;
   localparam int unsigned CTL_FCLR     = 3;
   localparam int unsigned CTL_MIN_W    = 4;
endpackage

// File: rtl/vtp_tick_sel.sv
module vtp_tick_sel
   import vtp_pkg::*;
#(
   parameter bit EXT_BOTH = 1'b1
) (
   input  logic [1:0] clk_sel,
   input  logic       tick_en,
   output logic       advance
);
   logic ext_hit;

   generate
      if (EXT_BOTH) begin : g_ext_both
         assign ext_hit = clk_sel[1] & tick_en;
      end else begin : g_ext_one
         assign ext_hit = (clk_sel == SRC_EXT0) & tick_en;
      end
   endgenerate

   always_comb begin
      case (clk_src_e'(clk_sel))
         SRC_STOP: advance = 1'b0;
         SRC_FREE: advance = 1'b1;
         default:  advance = ext_hit;
      endcase
   end
endmodule

// File: rtl/vtp_counter.sv
module vtp_counter #(
   parameter int unsigned CNT_W      = 8,
   parameter logic [CNT_W-1:0] PERIOD_RST = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   input  logic             cnt_wr,
   input  logic             per_wr,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] period_q,
   output logic [CNT_W-1:0] next_val,
   output logic             step,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic at_top;

   assign at_top   = (cnt_q == period_q);
   assign step     = advance & ~cnt_wr;
   assign wrap     = step & at_top;
   assign next_val = at_top ? '0 : cnt_q + ONE;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_wr) begin
         cnt_q <= wr_data;
      end else if (step) begin
         cnt_q <= next_val;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         period_q <= PERIOD_RST;
      end else if (per_wr) begin
         period_q <= wr_data;
      end
   end
endmodule

// File: rtl/vtp_duty_buf.sv
module vtp_duty_buf #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             duty_wr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             wrap,
   output logic [CNT_W-1:0] duty_hold,
   output logic [CNT_W-1:0] duty_act,
   output logic [CNT_W-1:0] duty_eff
);
   assign duty_eff = wrap ? duty_hold : duty_act;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         duty_hold <= '0;
      end else if (duty_wr) begin
         duty_hold <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         duty_act <= '0;
      end else if (wrap) begin
         duty_act <= duty_hold;
      end
   end
endmodule

// File: rtl/vtp_out_ctrl.sv
module vtp_out_ctrl
   import vtp_pkg::*;
#(
   parameter int unsigned CNT_W     = 8,
   parameter bit          SET_WINS  = 1'b1,
   parameter bit          IDLE_LVL  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [CNT_W-1:0] next_val,
   input  logic [CNT_W-1:0] duty_eff,
   input  logic             ctrl_wr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             irq_ack,
   output logic [1:0]       mode_q,
   output logic             match,
   output logic             pwm_out,
   output logic             cmp_flag
);
   logic       zero_hit;
   logic       force_req;
   logic [1:0] new_mode;
   logic       flag_clr;
   logic       lvl_q;
   logic       lvl_d;
   logic       flag_d;

   assign new_mode  = wr_data[CTL_MODE_LSB +: 2];
   assign force_req = ctrl_wr & wr_data[CTL_FORCE] & new_mode[1];
   assign flag_clr  = irq_ack | (ctrl_wr & wr_data[CTL_FCLR]);
   assign match     = step & (next_val == duty_eff);
   assign zero_hit  = step & (next_val == '0);

   always_comb begin
      lvl_d = lvl_q;
      if (force_req) begin
         lvl_d = new_mode[0];
      end else if (mode_q[1]) begin
         if (match) begin
            lvl_d = mode_q[0];
         end else if (zero_hit) begin
            lvl_d = ~mode_q[0];
         end
      end
   end

   generate
      if (SET_WINS) begin : g_set_wins
         always_comb begin
            if (match)         flag_d = 1'b1;
            else if (flag_clr) flag_d = 1'b0;
            else               flag_d = cmp_flag;
         end
      end else begin : g_clr_wins
         always_comb begin
            if (flag_clr)      flag_d = 1'b0;
            else if (match)    flag_d = 1'b1;
            else               flag_d = cmp_flag;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= 2'b00;
         lvl_q    <= 1'b0;
         cmp_flag <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            mode_q <= new_mode;
         end
         lvl_q    <= lvl_d;
         cmp_flag <= flag_d;
      end
   end

   assign pwm_out = mode_q[1] ? lvl_q : IDLE_LVL;
endmodule

// File: rtl/vtop_pwm_timer.sv
module vtop_pwm_timer
   import vtp_pkg::*;
#(
   parameter int unsigned CNT_W    = 8,
   parameter bit          SET_WINS = 1'b1,
   parameter bit          EXT_BOTH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [1:0]       clk_sel,
   input  logic             tick_en,
   input  logic             irq_ack,
   output logic             pwm_out,
   output logic             cmp_flag,
   output logic [CNT_W-1:0] count_out
);
   generate
      if (CNT_W < CTL_MIN_W) begin : g_bad_width
         $error("vtop_pwm_timer: CNT_W must hold the control bits");
      end
   endgenerate

   logic             advance;
   logic             ctrl_wr;
   logic             cnt_wr;
   logic             duty_wr;
   logic             per_wr;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] period_q;
   logic [CNT_W-1:0] next_val;
   logic             step;
   logic             wrap;
   logic [CNT_W-1:0] duty_hold;
   logic [CNT_W-1:0] duty_act;
   logic [CNT_W-1:0] duty_eff;
   logic [1:0]       mode_q;
   logic             match;

   assign ctrl_wr = wr_en & (wr_addr == REG_CTRL);
   assign cnt_wr  = wr_en & (wr_addr == REG_COUNT);
   assign duty_wr = wr_en & (wr_addr == REG_DUTY);
   assign per_wr  = wr_en & (wr_addr == REG_PERIOD);

   vtp_tick_sel #(.EXT_BOTH(EXT_BOTH)) u_tick (
      .clk_sel (clk_sel),
      .tick_en (tick_en),
      .advance (advance)
   );

   vtp_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .advance  (advance),
      .cnt_wr   (cnt_wr),
      .per_wr   (per_wr),
      .wr_data  (wr_data),
      .cnt_q    (cnt_q),
      .period_q (period_q),
      .next_val (next_val),
      .step     (step),
      .wrap     (wrap)
   );

   vtp_duty_buf #(.CNT_W(CNT_W)) u_duty (
      .clk       (clk),
      .rst_n     (rst_n),
      .duty_wr   (duty_wr),
      .wr_data   (wr_data),
      .wrap      (wrap),
      .duty_hold (duty_hold),
      .duty_act  (duty_act),
      .duty_eff  (duty_eff)
   );

   vtp_out_ctrl #(.CNT_W(CNT_W), .SET_WINS(SET_WINS)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .next_val (next_val),
      .duty_eff (duty_eff),
      .ctrl_wr  (ctrl_wr),
      .wr_data  (wr_data),
      .irq_ack  (irq_ack),
      .mode_q   (mode_q),
      .match    (match),
      .pwm_out  (pwm_out),
      .cmp_flag (cmp_flag)
   );

   assign count_out = cnt_q;
endmodule

// File: rtl/vtp_checker.sv
module vtp_checker #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             advance,
   input logic             cnt_wr,
   input logic [CNT_W-1:0] wr_data,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] period,
   input logic [CNT_W-1:0] duty_act,
   input logic             wrap,
   input logic             match,
   input logic             irq_ack,
   input logic             flag
);
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!advance && !cnt_wr) |=> $stable(cnt));

   assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !cnt_wr && cnt == period) |=> (cnt == '0));

   assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (cnt == $past(wr_data)));

   assert_buffer_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(duty_act));

   assert_flag_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
      match |=> flag);

   assert_flag_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !match) |=> !flag);
endmodule

bind vtop_pwm_timer vtp_checker #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .advance  (advance),
   .cnt_wr   (cnt_wr),
   .wr_data  (wr_data),
   .cnt      (cnt_q),
   .period   (period_q),
   .duty_act (duty_act),
   .wrap     (wrap),
   .match    (match),
   .irq_ack  (irq_ack),
   .flag     (cmp_flag)
);

// File: tb/vtop_pwm_timer_tb_top.sv
module vtop_pwm_timer_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [1:0] clk_sel = 2'd0;
   logic       tick_en = 1'b0;
   logic       irq_ack = 1'b0;
   logic       pwm_out;
   logic       cmp_flag;
   logic [7:0] count_out;

   int checks = 0;
   int fails = 0;
   int cycles = 0;
   bit done = 0;
   bit cmp_on = 0;
   string req = "R1";
   logic [15:0] lfsr = 16'hACE1;

   int m_cnt, m_per, m_hold, m_act, m_mode, m_lvl, m_flag;

   always #10 clk = ~clk;

   vtop_pwm_timer dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .clk_sel(clk_sel), .tick_en(tick_en),
      .irq_ack(irq_ack), .pwm_out(pwm_out), .cmp_flag(cmp_flag),
      .count_out(count_out)
   );

   // behavioural reference model
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_per = 255; m_hold = 0; m_act = 0;
         m_mode = 0; m_lvl = 0; m_flag = 0;
      end else begin
         bit adv, cw, wrapped, ev_zero, ev_match, frc, clr;
         int nv, eff, nmode;
         adv = (clk_sel == 2'd1) || (clk_sel[1] && tick_en);
         cw = wr_en && wr_addr == 2'd1;
         ev_zero = 0; ev_match = 0; wrapped = 0;
         if (!cw && adv) begin
            wrapped = (m_cnt == m_per);
            nv = wrapped ? 0 : (m_cnt + 1) % 256;
            eff = wrapped ? m_hold : m_act;
            ev_zero = (nv == 0);
            ev_match = (nv == eff);
         end
         nmode = wr_data[1:0];
         frc = wr_en && wr_addr == 2'd0 && wr_data[2] && nmode >= 2;
         clr = irq_ack || (wr_en && wr_addr == 2'd0 && wr_data[3]);
         if (frc) m_lvl = nmode % 2;
         else if (m_mode >= 2) begin
            if (ev_match) m_lvl = m_mode % 2;
            else if (ev_zero) m_lvl = 1 - (m_mode % 2);
         end
         if (ev_match) m_flag = 1;
         else if (clr) m_flag = 0;
         if (wrapped) m_act = m_hold;
         if (cw) m_cnt = wr_data;
         else if (adv) m_cnt = nv;
         if (wr_en && wr_addr == 2'd0) m_mode = nmode;
         if (wr_en && wr_addr == 2'd2) m_hold = wr_data;
         if (wr_en && wr_addr == 2'd3) m_per = wr_data;
      end
   end

   task automatic chk(string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on && rst_n) begin
         chk("count", count_out, m_cnt);
         chk("pwm", pwm_out, (m_mode >= 2) ? m_lvl : 0);
         chk("flag", cmp_flag, m_flag);
      end
   end

   // prescaler enable pattern
   always @(posedge clk) begin
      #3;
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tick_en <= lfsr[0];
   end

   task automatic cyc(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #2;
      end
   endtask

   task automatic wr(int a, int d);
      wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[7:0];
      cyc(1);
      wr_en = 1'b0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      req = "R1";
      chk("reset count", count_out, 0);
      chk("reset pwm", pwm_out, 0);
      chk("reset flag", cmp_flag, 0);
      cmp_on = 1;
      cyc(3);
      // R1 period 255 and R2 free run through the natural wrap
      req = "R2"; clk_sel = 2'd1; cyc(300);
      req = "R2"; clk_sel = 2'd0; cyc(10);
      req = "R2"; clk_sel = 2'd2; cyc(60);
      clk_sel = 2'd3; cyc(60);
      // R3 short period
      req = "R3"; clk_sel = 2'd1; wr(3, 9); cyc(40);
      // R6 non-inverted
      req = "R6"; wr(2, 3); wr(0, 8'h02); cyc(40);
      // R8 duty change mid period
      req = "R8"; cyc(2); wr(2, 7); cyc(30);
      // R11 acknowledge and clear bit
      req = "R11"; irq_ack = 1'b1; cyc(1); irq_ack = 1'b0; cyc(5);
      wr(0, 8'h0A); cyc(20);
      irq_ack = 1'b1; cyc(25); irq_ack = 1'b0;
      // R7 inverted
      req = "R7"; wr(0, 8'h03); cyc(40);
      wr(2, 0); cyc(30);
      // R9 duty above period
      req = "R9"; wr(2, 20); cyc(40);
      wr(0, 8'h02); cyc(30);
      // R4 counter write during advance
      req = "R4"; wr(1, 5); wr(1, 200); cyc(80); wr(3, 100); wr(1, 99); cyc(10);
      // R10 force with counter stopped
      req = "R10"; clk_sel = 2'd0; wr(2, 50);
      wr(0, 8'h07); cyc(3);
      chk("force inverted level", pwm_out, 1);
      wr(0, 8'h06); cyc(3);
      chk("force non-inverted level", pwm_out, 0);
      chk("force leaves flag", cmp_flag, m_flag);
      // R5 disconnected modes
      req = "R5"; clk_sel = 2'd1; wr(0, 8'h01); cyc(150);
      chk("mode01 pwm", pwm_out, 0);
      wr(0, 8'h00); cyc(50);
      chk("mode00 pwm", pwm_out, 0);
      // R3 maximum top and back to small
      req = "R3"; wr(0, 8'h02); wr(3, 255); wr(2, 128); cyc(600);
      wr(3, 0); cyc(20);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule